// File: doc/BRIEF.md
# Compare-Clearing Timer/Counter

This block is a timer/counter that advances once per enabled tick from an external prescaler. A mode input selects between a single 8-bit counter and a joined 16-bit counter, and a second mode input selects free-running counting or counting that restarts from zero once the count reaches a programmed TOP value. Software-side logic writes the counter and two compare bytes through simple write strobes. The block reports events through a sticky overflow flag, a sticky compare flag and a single-cycle compare pulse. Each flag is cleared by its own acknowledge input.

The compare bytes take effect on the cycle after they are written; no shadow copy exists. A TOP value lowered beneath the running count is therefore missed. The counter then climbs to its maximum, wraps, raises overflow, and only meets TOP on the following lap. Software that retunes the period while the timer runs has to plan around this behaviour.

Top module: `cmp_timer`

## Requirements
- R1: After reset the count output is zero, both flags and the compare pulse are low, and both compare bytes are zero.
- R2: The count changes only on a cycle with `tick_en` high or `wr_cnt` high. Otherwise it holds its value.
- R3: A tick taken while the count equals the maximum (0xFF in 8-bit mode, 0xFFFF in 16-bit mode) makes the next count zero and sets `ovf_flag` at that same edge. This applies in both modes, including a compare clear whose TOP equals the maximum.
- R4: When `clr_on_cmp` is 1, a tick taken while the count equals TOP makes the next count zero. TOP is compare byte lo in 8-bit mode. In 16-bit mode TOP is {compare byte hi, compare byte lo}, with hi as bits 15:8.
- R5: A tick taken while the count equals TOP sets `cmp_flag` and raises `cmp_pulse` for exactly one cycle at the same edge, in both counting modes. When `clr_on_cmp` is 0, the count then simply increments.
- R6: Compare bytes are used unbuffered. If TOP is written below the current count, the counter runs to the maximum, wraps with overflow, and matches only when it next reaches TOP.
- R7: `ovf_flag` stays set until a cycle with `ovf_ack` high clears it. If the flag is set and acknowledged in the same cycle, it ends set.
- R8: `cmp_flag` stays set until a cycle with `cmp_ack` high clears it. If the flag is set and acknowledged in the same cycle, it ends set.
- R9: `wr_cnt` loads the count on the next edge and overrides any tick in that cycle. That cycle sets neither flag and produces no pulse.
- R10: When `wide_mode` is 0, only count bits 7:0 and compare byte lo are used. Compare byte hi is ignored, count bits 15:8 read zero after any load or tick, and 0x00FF ticks to 0x0000. When `wide_mode` is 1, 0x00FF ticks to 0x0100 without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Prescaler tick; the counter steps on cycles where this is high |
| wide_mode | input | 1 | 1 = joined 16-bit counter, 0 = 8-bit counter |
| clr_on_cmp | input | 1 | 1 = restart from zero at TOP, 0 = free-running |
| wr_cnt | input | 1 | Load strobe for the count |
| wr_cnt_data | input | 16 | Value to load into the count |
| wr_cmp_lo | input | 1 | Write strobe for compare byte lo |
| wr_cmp_hi | input | 1 | Write strobe for compare byte hi |
| wr_cmp_data | input | 8 | Data for either compare byte |
| ovf_ack | input | 1 | Clears the overflow flag |
| cmp_ack | input | 1 | Clears the compare flag |
| count | output | 16 | Current count value |
| ovf_flag | output | 1 | Sticky overflow flag |
| cmp_flag | output | 1 | Sticky compare-match flag |
| cmp_pulse | output | 1 | One-cycle pulse on each compare match |

## Verification
The bench lowers TOP beneath a running count and steps the counter through a full lap. A design that double-buffered TOP, or compared with greater-or-equal, would clear early instead of wrapping with overflow first. It collides set and acknowledge on both flags in one cycle, where a clear-wins design drops the event. It puts a load and a tick in the same cycle at TOP and at the maximum, where a design that lets the tick through would clear, increment or raise a flag. It also drives 0x00FF in both widths and loads a nonzero upper byte in 8-bit mode, which exposes a carry that leaks into the upper byte or an upper byte left unmasked.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
   typedef enum logic [0:0] {
      MODE_FREE  = 1'b0,
      MODE_CLEAR = 1'b1
   } tmr_mode_e;

   localparam int FLG_OVF = 0;
   localparam int FLG_CMP = 1;
   localparam int NUM_FLG = 2;
endpackage

// File: rtl/cmp_timer_regs.sv
module cmp_timer_regs #(
   parameter int BYTE_W  = 8,
   parameter bit WIDE_EN = 1'b1,
   localparam int CNT_W  = 2 * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wide_i,
   input  logic              wr_lo_i,
   input  logic              wr_hi_i,
   input  logic [BYTE_W-1:0] wr_data_i,
   output logic [CNT_W-1:0]  top_o
);
   logic [BYTE_W-1:0] lo_q;
   logic [BYTE_W-1:0] hi_q;

   always_ff @(posedge clk) begin
      if (!rst_n)       lo_q <= '0;
      else if (wr_lo_i) lo_q <= wr_data_i;
   end

   generate
      if (WIDE_EN) begin : g_hi_reg
         always_ff @(posedge clk) begin
            if (!rst_n)       hi_q <= '0;
            else if (wr_hi_i) hi_q <= wr_data_i;
         end
      end else begin : g_hi_none
         assign hi_q = '0;
      end
   endgenerate

   // Upper byte of TOP only counts in the joined mode (R10).
   assign top_o = wide_i ? {hi_q, lo_q} : {{BYTE_W{1'b0}}, lo_q};

   assert_narrow_top_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !wide_i |-> top_o[CNT_W-1:BYTE_W] == '0);
endmodule

// File: rtl/cmp_timer_core.sv
module cmp_timer_core
   import cmp_timer_pkg::*;
#(
   parameter int BYTE_W = 8,
   localparam int CNT_W = 2 * BYTE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             wide_i,
   input  logic             clr_i,
   input  logic             wr_i,
   input  logic [CNT_W-1:0] wr_data_i,
   input  logic [CNT_W-1:0] top_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             ovf_set_o,
   output logic             cmp_set_o
);
   localparam logic [CNT_W-1:0] MAX_WIDE   = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] MAX_NARROW = {{BYTE_W{1'b0}}, {BYTE_W{1'b1}}};

   tmr_mode_e        mode;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cur;
   logic [CNT_W-1:0] max_val;
   logic [CNT_W-1:0] load_val;
   logic [CNT_W-1:0] nxt;
   logic             step;
   logic             hit;
   logic             at_max;

   assign mode     = tmr_mode_e'(clr_i);
   assign cur      = wide_i ? cnt_q : {{BYTE_W{1'b0}}, cnt_q[BYTE_W-1:0]};
   assign max_val  = wide_i ? MAX_WIDE : MAX_NARROW;
   assign load_val = wide_i ? wr_data_i : {{BYTE_W{1'b0}}, wr_data_i[BYTE_W-1:0]};
   assign step     = tick_i && !wr_i;
   assign hit      = (cur == top_i);
   assign at_max   = (cur == max_val);

   always_comb begin
      nxt = cnt_q;
      if (wr_i)                              nxt = load_val;
      else if (step) begin
         if (mode == MODE_CLEAR && hit)      nxt = '0;
         else if (at_max)                    nxt = '0;
         else                                nxt = cur + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= nxt;
   end

   assign cnt_o     = cnt_q;
   assign ovf_set_o = step && at_max;
   assign cmp_set_o = step && hit;

   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !wr_i) |=> $stable(cnt_o));
   assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !wr_i && cnt_o == MAX_WIDE && wide_i) |=> cnt_o == '0);
   assert_clear_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !wr_i && clr_i && cur == top_i) |=> cnt_o == '0);
   assert_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> cnt_o[BYTE_W-1:0] == $past(wr_data_i[BYTE_W-1:0]));
   assert_upper_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!wide_i && (tick_i || wr_i)) |=> cnt_o[CNT_W-1:BYTE_W] == '0);
endmodule

// File: rtl/cmp_timer_flag.sv
module cmp_timer_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   logic flag_q;

   always_ff @(posedge clk) begin
      if (!rst_n)     flag_q <= 1'b0;
      else if (set_i) flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
   end

   assign flag_o = flag_q;

   // Set beats acknowledge (R7 for overflow, R8 for compare).
   assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> flag_o);
   assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !flag_o);
   assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o && !clr_i) |=> flag_o);
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
   import cmp_timer_pkg::*;
#(
   parameter int BYTE_W  = 8,
   parameter bit WIDE_EN = 1'b1,
   localparam int CNT_W  = 2 * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              wide_mode,
   input  logic              clr_on_cmp,
   input  logic              wr_cnt,
   input  logic [CNT_W-1:0]  wr_cnt_data,
   input  logic              wr_cmp_lo,
   input  logic              wr_cmp_hi,
   input  logic [BYTE_W-1:0] wr_cmp_data,
   input  logic              ovf_ack,
   input  logic              cmp_ack,
   output logic [CNT_W-1:0]  count,
   output logic              ovf_flag,
   output logic              cmp_flag,
   output logic              cmp_pulse
);
   initial begin
      if (BYTE_W < 2)  $error("cmp_timer: BYTE_W must be at least 2");
      if (BYTE_W > 32) $error("cmp_timer: BYTE_W must not exceed 32");
   end

   logic               wide_eff;
   logic [CNT_W-1:0]   top_val;
   logic               ovf_set;
   logic               cmp_set;
   logic               pulse_q;
   logic [NUM_FLG-1:0] flg_set;
   logic [NUM_FLG-1:0] flg_clr;
   logic [NUM_FLG-1:0] flg_q;

   generate
      if (WIDE_EN) begin : g_wide
         assign wide_eff = wide_mode;
      end else begin : g_narrow
         assign wide_eff = 1'b0;
      end
   endgenerate

   cmp_timer_regs #(.BYTE_W(BYTE_W), .WIDE_EN(WIDE_EN)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wide_i    (wide_eff),
      .wr_lo_i   (wr_cmp_lo),
      .wr_hi_i   (wr_cmp_hi),
      .wr_data_i (wr_cmp_data),
      .top_o     (top_val)
   );

   cmp_timer_core #(.BYTE_W(BYTE_W)) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (tick_en),
      .wide_i    (wide_eff),
      .clr_i     (clr_on_cmp),
      .wr_i      (wr_cnt),
      .wr_data_i (wr_cnt_data),
      .top_i     (top_val),
      .cnt_o     (count),
      .ovf_set_o (ovf_set),
      .cmp_set_o (cmp_set)
   );

   assign flg_set[FLG_OVF] = ovf_set;
   assign flg_clr[FLG_OVF] = ovf_ack;
   assign flg_set[FLG_CMP] = cmp_set;
   assign flg_clr[FLG_CMP] = cmp_ack;

   generate
      for (genvar f = 0; f < NUM_FLG; f++) begin : g_flag
         cmp_timer_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (flg_set[f]),
            .clr_i  (flg_clr[f]),
            .flag_o (flg_q[f])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) pulse_q <= 1'b0;
      else        pulse_q <= cmp_set;
   end

   assign ovf_flag  = flg_q[FLG_OVF];
   assign cmp_flag  = flg_q[FLG_CMP];
   assign cmp_pulse = pulse_q;

   assert_pulse_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_pulse |-> cmp_flag);
   assert_pulse_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_pulse && !tick_en) |=> !cmp_pulse);
   assert_load_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cnt |=> !cmp_pulse);
endmodule

// File: tb/cmp_timer_tb.sv
module cmp_timer_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0;
   logic        wide_mode = 1'b0;
   logic        clr_on_cmp = 1'b0;
   logic        wr_cnt = 1'b0;
   logic [15:0] wr_cnt_data = '0;
   logic        wr_cmp_lo = 1'b0;
   logic        wr_cmp_hi = 1'b0;
   logic [7:0]  wr_cmp_data = '0;
   logic        ovf_ack = 1'b0;
   logic        cmp_ack = 1'b0;
   logic [15:0] count;
   logic        ovf_flag;
   logic        cmp_flag;
   logic        cmp_pulse;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   cmp_timer u_dut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wide_mode(wide_mode),
      .clr_on_cmp(clr_on_cmp), .wr_cnt(wr_cnt), .wr_cnt_data(wr_cnt_data),
      .wr_cmp_lo(wr_cmp_lo), .wr_cmp_hi(wr_cmp_hi), .wr_cmp_data(wr_cmp_data),
      .ovf_ack(ovf_ack), .cmp_ack(cmp_ack), .count(count),
      .ovf_flag(ovf_flag), .cmp_flag(cmp_flag), .cmp_pulse(cmp_pulse)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic clk1();
      @(posedge clk);
      #1;
   endtask

   task automatic ticks(input int n);
      tick_en = 1'b1;
      repeat (n) clk1();
      tick_en = 1'b0;
   endtask

   task automatic load(input logic [15:0] v);
      wr_cnt = 1'b1; wr_cnt_data = v;
      clk1();
      wr_cnt = 1'b0;
   endtask

   task automatic set_lo(input logic [7:0] v);
      wr_cmp_lo = 1'b1; wr_cmp_data = v;
      clk1();
      wr_cmp_lo = 1'b0;
   endtask

   task automatic set_hi(input logic [7:0] v);
      wr_cmp_hi = 1'b1; wr_cmp_data = v;
      clk1();
      wr_cmp_hi = 1'b0;
   endtask

   task automatic clear_flags();
      ovf_ack = 1'b1; cmp_ack = 1'b1;
      clk1();
      ovf_ack = 1'b0; cmp_ack = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 count", count, 0);
      chk("R1 ovf_flag", ovf_flag, 0);
      chk("R1 cmp_flag", cmp_flag, 0);
      chk("R1 cmp_pulse", cmp_pulse, 0);
   endtask

   task automatic t_hold();
      ticks(3);
      chk("R2 count after 3 ticks", count, 3);
      repeat (5) clk1();
      chk("R2 count held without ticks", count, 3);
      clear_flags();
   endtask

   task automatic t_norm8_wrap();
      wide_mode = 1'b0; clr_on_cmp = 1'b0;
      clear_flags();
      load(16'h00FD);
      ticks(2);
      chk("R3 count at max", count, 'hFF);
      chk("R3 no ovf before wrap", ovf_flag, 0);
      ticks(1);
      chk("R3 wrap to zero", count, 0);
      chk("R3 ovf set at wrap", ovf_flag, 1);
      repeat (4) clk1();
      chk("R7 ovf sticky", ovf_flag, 1);
      ovf_ack = 1'b1; clk1(); ovf_ack = 1'b0;
      chk("R7 ovf cleared by ack", ovf_flag, 0);
      load(16'h00FF);
      ovf_ack = 1'b1; tick_en = 1'b1; clk1(); ovf_ack = 1'b0; tick_en = 1'b0;
      chk("R7 set wins over ack", ovf_flag, 1);
      clear_flags();
   endtask

   task automatic t_ctc8();
      wide_mode = 1'b0; clr_on_cmp = 1'b1;
      set_hi(8'h12);
      set_lo(8'h05);
      load(16'h0000);
      clear_flags();
      ticks(5);
      chk("R4 count reaches TOP", count, 5);
      chk("R5 no flag before match tick", cmp_flag, 0);
      ticks(1);
      chk("R4 clear at TOP", count, 0);
      chk("R5 cmp_flag set", cmp_flag, 1);
      chk("R5 cmp_pulse high", cmp_pulse, 1);
      clk1();
      chk("R5 cmp_pulse one cycle", cmp_pulse, 0);
      chk("R8 cmp_flag sticky", cmp_flag, 1);
      cmp_ack = 1'b1; clk1(); cmp_ack = 1'b0;
      chk("R8 cmp_flag cleared", cmp_flag, 0);
      ticks(6);
      chk("R10 period ignores hi byte", count, 0);
      chk("R10 second match flag", cmp_flag, 1);
      clear_flags();
   endtask

   task automatic t_missed();
      wide_mode = 1'b0; clr_on_cmp = 1'b1;
      set_lo(8'h40);
      load(16'h0030);
      set_lo(8'h10);
      clear_flags();
      ticks(8'hCF);
      chk("R6 runs past lowered TOP to max", count, 'hFF);
      chk("R6 no match on the way", cmp_flag, 0);
      ticks(1);
      chk("R6 wraps to zero", count, 0);
      chk("R6 overflow on wrap", ovf_flag, 1);
      ticks(8'h10);
      chk("R6 reaches new TOP", count, 'h10);
      chk("R6 still no match", cmp_flag, 0);
      ticks(1);
      chk("R6 clears at new TOP", count, 0);
      chk("R6 match after wrap", cmp_flag, 1);
      clear_flags();
   endtask

   task automatic t_write_prio();
      wide_mode = 1'b0; clr_on_cmp = 1'b1;
      set_lo(8'h05);
      load(16'h0005);
      clear_flags();
      wr_cnt = 1'b1; wr_cnt_data = 16'h0020; tick_en = 1'b1;
      clk1();
      wr_cnt = 1'b0; tick_en = 1'b0;
      chk("R9 load beats clear", count, 'h20);
      chk("R9 no pulse on load", cmp_pulse, 0);
      chk("R9 no cmp flag on load", cmp_flag, 0);
      load(16'h00FF);
      wr_cnt = 1'b1; wr_cnt_data = 16'h0007; tick_en = 1'b1;
      clk1();
      wr_cnt = 1'b0; tick_en = 1'b0;
      chk("R9 load beats wrap", count, 7);
      chk("R9 no ovf on load", ovf_flag, 0);
      load(16'h0005);
      cmp_ack = 1'b1; tick_en = 1'b1; clk1(); cmp_ack = 1'b0; tick_en = 1'b0;
      chk("R8 set wins over ack", cmp_flag, 1);
      clear_flags();
   endtask

   task automatic t_norm_match();
      wide_mode = 1'b0; clr_on_cmp = 1'b0;
      set_lo(8'h05);
      load(16'h0004);
      clear_flags();
      ticks(1);
      chk("R5 count at TOP", count, 5);
      chk("R5 no flag yet", cmp_flag, 0);
      ticks(1);
      chk("R5 free mode keeps counting", count, 6);
      chk("R5 free mode match flag", cmp_flag, 1);
      clear_flags();
   endtask

   task automatic t_wide();
      wide_mode = 1'b1; clr_on_cmp = 1'b0;
      set_lo(8'h00); set_hi(8'h00);
      load(16'hFFFE);
      clear_flags();
      ticks(1);
      chk("R3 16-bit max", count, 'hFFFF);
      chk("R3 16-bit no ovf yet", ovf_flag, 0);
      ticks(1);
      chk("R3 16-bit wrap", count, 0);
      chk("R3 16-bit ovf", ovf_flag, 1);
      clear_flags();
      load(16'h00FF);
      ticks(1);
      chk("R10 16-bit carry into hi", count, 'h0100);
      chk("R10 16-bit no ovf at 0xFF", ovf_flag, 0);
      clr_on_cmp = 1'b1;
      set_hi(8'h01); set_lo(8'h02);
      load(16'h0100);
      clear_flags();
      ticks(2);
      chk("R4 16-bit at TOP", count, 'h0102);
      chk("R4 16-bit no flag yet", cmp_flag, 0);
      ticks(1);
      chk("R4 16-bit clear at TOP", count, 0);
      chk("R4 16-bit cmp flag", cmp_flag, 1);
      clear_flags();
   endtask

   task automatic t_narrow_upper();
      wide_mode = 1'b0; clr_on_cmp = 1'b0;
      set_lo(8'h30);
      clear_flags();
      load(16'h12FE);
      chk("R10 upper byte dropped on load", count, 'h00FE);
      ticks(2);
      chk("R10 8-bit wrap", count, 0);
      chk("R10 8-bit ovf", ovf_flag, 1);
      clear_flags();
   endtask

   initial begin
      repeat (3) clk1();
      rst_n = 1'b1;
      clk1();
      t_reset();
      t_hold();
      t_norm8_wrap();
      t_ctc8();
      t_missed();
      t_write_prio();
      t_norm_match();
      t_wide();
      t_narrow_upper();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule